// File: doc/BRIEF.md
# Gated Power-of-Two Clock Divider Bank

This block produces a set of divided clock outputs from a single reference clock. Each output divides the reference by a power of two between 1 and 64 and is gated by its own enable bit. The outputs start and stop without truncated pulses. Software programs each output through a byte-wide register port. The port has an address, write data with a write strobe, and a read strobe with combinational read data.

Each output owns a window of 256 addresses. The upper address bits pick the output and the low byte picks the register. For each output, a status line reports when the output can be relied on: it rises a fixed number of reference cycles after enabling, and it falls a fixed number of reference cycles after disabling. Both counts depend on the divide ratio. A ratio change written while an output runs is held back until the output's next low phase, so no pulse is cut short.

Top module: `clkdiv_bank`

## Requirements
- R1: Divide code 0 and code 1 both give divide-by-1, where the output follows the reference clock. Code c from 2 to 7 gives divide-by-2^(c-1), and the output is high for exactly half of each output period.
- R2: The divide code is held in bits 2:0 of the register at low-byte offset 0x43. It reads back from that register, and bits 7:3 read as zero.
- R3: The enable is bit 7 of the register at low-byte offset 0x46. Reading it back returns the enable state in bit 7, and bits 6:0 read as zero.
- R4: Output k is selected by address bits 15:8 equal to k. Each output's registers are independent of the others. Writes to an output index at or above the number of outputs, or to any other offset, change nothing, and reads from them return zero.
- R5: After reset every divide code and enable is zero, every output is low and every status line is low.
- R6: Let R be the ratio of the programmed code. After the write that sets the enable, the output shows its first rising edge within 2+3R reference cycles. The status line rises exactly 2+3R reference cycles after that write.
- R7: After the write that clears the enable, the status line falls exactly 3R reference cycles later. By then the output is low and stays low.
- R8: No high pulse on any output is shorter than the half period of a supported ratio. The gate opens and closes only while the divided clock is low.
- R9: A divide code written while the output runs takes effect at the start of the next low phase. The output then settles on the new period.
- R10: Read data is zero whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (16) | Register address: output index in the upper bits, offset in the low byte |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_wr | input | 1 | Write strobe, sampled on the rising reference edge |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | DATA_W (8) | Combinational read data, zero when not reading |
| clk_out | output | N_CH (3) | Divided and gated clock outputs |
| running | output | N_CH (3) | Per-output status after the enable or disable latency |

## Verification
The bench times the status line against the exact latency, in reference cycles, for every ratio. A counter that was off by one, or that took its limit from the wrong direction, would move that edge. Every high pulse on every output is timed. A gate that closed in mid-pulse, or a ratio handed over while the output was high, would leave a width that matches no half period. The bench rewrites the ratio while an output runs and checks the settled period. It also writes to an output index beyond the bank and to unmapped offsets, then reads back the real registers. A loose address decode would show there as a changed code or as non-zero read data.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   localparam int CODE_W    = 3;
   localparam int MAX_SHIFT = (1 << CODE_W) - 2;
   localparam int MAX_RATIO = 1 << MAX_SHIFT;
   localparam int CNT_W     = MAX_SHIFT - 1;
   localparam int LAT_W     = $clog2(2 + 3 * MAX_RATIO + 1);

   typedef logic [CODE_W-1:0] code_t;

   function automatic logic is_unity(code_t c);
      return (c <= code_t'(1));
   endfunction

   function automatic int ratio_of(code_t c);
      if (is_unity(c)) return 1;
      return 1 << (int'(c) - 1);
   endfunction

   function automatic logic [CNT_W-1:0] half_m1_of(code_t c);
      if (is_unity(c)) return '0;
      return CNT_W'((1 << (int'(c) - 2)) - 1);
   endfunction

   function automatic logic [LAT_W-1:0] lat_lim(code_t c, logic turning_on);
      int r;
      r = ratio_of(c);
      return turning_on ? LAT_W'(2 + 3 * r) : LAT_W'(3 * r);
   endfunction
endpackage

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
   import clkdiv_pkg::*;
(
   input  logic  clk_ref,
   input  logic  rst_n,
   input  code_t code_i,
   input  logic  en_i,
   output logic  clk_o,
   output logic  slow_o,
   output logic  fast_o
);
   code_t            eff_q, eff_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             ph_q, ph_d;
   logic             open_q, open_d;
   logic             slow_q, fast_q;
   logic             unity, active, wrap;

   assign unity  = is_unity(eff_q);
   assign active = en_i | open_q;
   assign wrap   = (cnt_q == half_m1_of(eff_q));

   always_comb begin
      eff_d  = eff_q;
      cnt_d  = cnt_q;
      ph_d   = ph_q;
      open_d = open_q;
      if (!active) begin
         eff_d = code_i;
         cnt_d = '0;
         ph_d  = 1'b0;
      end else if (unity) begin
         eff_d  = code_i;
         cnt_d  = '0;
         ph_d   = 1'b0;
         open_d = en_i;
      end else begin
         if (wrap) begin
            cnt_d = '0;
            ph_d  = ~ph_q;
            if (ph_q) eff_d = code_i;
         end else begin
            cnt_d = cnt_q + CNT_W'(1);
         end
         if (!ph_q) open_d = en_i;
      end
   end

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         eff_q  <= '0;
         cnt_q  <= '0;
         ph_q   <= 1'b0;
         open_q <= 1'b0;
         slow_q <= 1'b0;
      end else begin
         eff_q  <= eff_d;
         cnt_q  <= cnt_d;
         ph_q   <= ph_d;
         open_q <= open_d;
         slow_q <= open_d & ph_d;
      end
   end

   always_ff @(negedge clk_ref or negedge rst_n) begin
      if (!rst_n) fast_q <= 1'b0;
      else        fast_q <= open_q & unity;
   end

   assign clk_o  = fast_q ? clk_ref : slow_q;
   assign slow_o = slow_q;
   assign fast_o = fast_q;
endmodule

// File: rtl/clkdiv_status.sv
module clkdiv_status
   import clkdiv_pkg::*;
(
   input  logic  clk_ref,
   input  logic  rst_n,
   input  code_t code_i,
   input  logic  en_i,
   output logic  running_o
);
   logic [LAT_W-1:0] lat_q;
   logic [LAT_W-1:0] lim;
   logic             run_q;

   assign lim = lat_lim(code_i, en_i);

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
         run_q <= 1'b0;
      end else if (en_i == run_q) begin
         lat_q <= '0;
      end else if (lat_q == lim - LAT_W'(1)) begin
         run_q <= en_i;
         lat_q <= '0;
      end else begin
         lat_q <= lat_q + LAT_W'(1);
      end
   end

   assign running_o = run_q;
endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
   import clkdiv_pkg::*;
#(
   parameter int N_CH        = 3,
   parameter int ADDR_W      = 16,
   parameter int STRIDE_LOG2 = 8,
   parameter int DATA_W      = 8,
   parameter int DIV_OFS     = 'h43,
   parameter int EN_OFS      = 'h46,
   parameter int EN_BIT      = 7
) (
   input  logic                    clk_ref,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       reg_addr,
   input  logic [DATA_W-1:0]       reg_wdata,
   input  logic                    reg_wr,
   input  logic                    reg_rd,
   output logic [DATA_W-1:0]       reg_rdata,
   output code_t [N_CH-1:0]        code_o,
   output logic  [N_CH-1:0]        en_o
);
   localparam int SEL_W = ADDR_W - STRIDE_LOG2;

   logic [SEL_W-1:0]       sel;
   logic [STRIDE_LOG2-1:0] ofs;
   logic                   hit_div, hit_en;
   logic                   unused_wdata;

   assign sel          = reg_addr[ADDR_W-1:STRIDE_LOG2];
   assign ofs          = reg_addr[STRIDE_LOG2-1:0];
   assign hit_div      = (ofs == STRIDE_LOG2'(DIV_OFS));
   assign hit_en       = (ofs == STRIDE_LOG2'(EN_OFS));
   assign unused_wdata = ^reg_wdata;

   for (genvar i = 0; i < N_CH; i++) begin : g_reg
      code_t code_q;
      logic  en_q;
      logic  mine;
      assign mine = reg_wr && (sel == SEL_W'(i));
      always_ff @(posedge clk_ref or negedge rst_n) begin
         if (!rst_n) begin
            code_q <= '0;
            en_q   <= 1'b0;
         end else if (mine) begin
            if (hit_div) code_q <= reg_wdata[CODE_W-1:0];
            if (hit_en)  en_q   <= reg_wdata[EN_BIT];
         end
      end
      assign code_o[i] = code_q;
      assign en_o[i]   = en_q;
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         for (int i = 0; i < N_CH; i++) begin
            if (sel == SEL_W'(i)) begin
               if (hit_div) reg_rdata[CODE_W-1:0] = code_o[i];
               if (hit_en)  reg_rdata[EN_BIT]     = en_o[i];
            end
         end
      end
   end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
   import clkdiv_pkg::*;
#(
   parameter int N_CH        = 3,
   parameter int ADDR_W      = 16,
   parameter int STRIDE_LOG2 = 8,
   parameter int DATA_W      = 8,
   parameter int DIV_OFS     = 'h43,
   parameter int EN_OFS      = 'h46,
   parameter int EN_BIT      = 7
) (
   input  logic              clk_ref,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_wr,
   input  logic              reg_rd,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [N_CH-1:0]   clk_out,
   output logic [N_CH-1:0]   running
);
   if (N_CH < 1 || N_CH > (1 << (ADDR_W - STRIDE_LOG2))) begin : g_bad_n
      $error("clkdiv_bank: N_CH does not fit the address map");
   end
   if (EN_BIT >= DATA_W || CODE_W > DATA_W) begin : g_bad_w
      $error("clkdiv_bank: register fields exceed DATA_W");
   end
   if (DIV_OFS == EN_OFS || DIV_OFS >= (1 << STRIDE_LOG2) || EN_OFS >= (1 << STRIDE_LOG2)) begin : g_bad_ofs
      $error("clkdiv_bank: register offsets overlap or leave the window");
   end

   code_t [N_CH-1:0] code_vec;
   logic  [N_CH-1:0] en_vec;
   logic  [N_CH-1:0] slow_vec;
   logic  [N_CH-1:0] fast_vec;

   clkdiv_regs #(
      .N_CH(N_CH), .ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2), .DATA_W(DATA_W),
      .DIV_OFS(DIV_OFS), .EN_OFS(EN_OFS), .EN_BIT(EN_BIT)
   ) u_regs (
      .clk_ref(clk_ref), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .code_o(code_vec), .en_o(en_vec)
   );

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      clkdiv_chan u_chan (
         .clk_ref(clk_ref), .rst_n(rst_n), .code_i(code_vec[i]), .en_i(en_vec[i]),
         .clk_o(clk_out[i]), .slow_o(slow_vec[i]), .fast_o(fast_vec[i])
      );
      clkdiv_status u_stat (
         .clk_ref(clk_ref), .rst_n(rst_n), .code_i(code_vec[i]), .en_i(en_vec[i]),
         .running_o(running[i])
      );
   end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
   import clkdiv_pkg::*;
#(
   parameter int N_CH        = 3,
   parameter int ADDR_W      = 16,
   parameter int STRIDE_LOG2 = 8,
   parameter int DATA_W      = 8
) (
   input logic              clk_ref,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [DATA_W-1:0] reg_rdata,
   input code_t [N_CH-1:0]  code_vec,
   input logic [N_CH-1:0]   en_vec,
   input logic [N_CH-1:0]   slow_vec,
   input logic [N_CH-1:0]   fast_vec,
   input logic [N_CH-1:0]   running
);
   localparam int SEL_W = ADDR_W - STRIDE_LOG2;

   a_r10_rdata_idle: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !reg_rd |-> reg_rdata == '0);

   for (genvar i = 0; i < N_CH; i++) begin : g_chk
      a_r6_rise_after_enable: assert property (@(posedge clk_ref) disable iff (!rst_n)
         $rose(running[i]) |-> $past(en_vec[i]));
      a_r7_fall_after_disable: assert property (@(posedge clk_ref) disable iff (!rst_n)
         $fell(running[i]) |-> !$past(en_vec[i]));
      a_r7_quiet_at_fall: assert property (@(posedge clk_ref) disable iff (!rst_n)
         $fell(running[i]) |-> (!slow_vec[i] && !fast_vec[i]));
      a_r4_other_write_ignored: assert property (@(posedge clk_ref) disable iff (!rst_n)
         (reg_wr && reg_addr[ADDR_W-1:STRIDE_LOG2] != SEL_W'(i))
         |=> ($stable(code_vec[i]) && $stable(en_vec[i])));
   end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(
   .N_CH(N_CH), .ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2), .DATA_W(DATA_W)
) u_chk (
   .clk_ref(clk_ref), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .reg_rd(reg_rd), .reg_rdata(reg_rdata), .code_vec(code_vec), .en_vec(en_vec),
   .slow_vec(slow_vec), .fast_vec(fast_vec), .running(running)
);

// File: tb/clkdiv_bank_tb.sv
`timescale 1ns/1ps
module clkdiv_bank_tb;
   localparam int N = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [7:0]  reg_rdata;
   logic [N-1:0] clk_out;
   logic [N-1:0] running;

   always #2.5 clk = ~clk;

   clkdiv_bank u_dut (
      .clk_ref(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .clk_out(clk_out), .running(running)
   );

   int n_chk = 0;
   int n_fail = 0;
   int runts = 0;
   realtime rise_t [N];
   realtime prev_rise_t [N];
   int rises [N];
   int hi_ps [N];
   logic [N-1:0] prev_o = '0;

   function automatic int ratio(int code);
      return (code < 2) ? 1 : (1 << (code - 1));
   endfunction

   function automatic bit legal_width(int ps);
      for (int k = 0; k <= 6; k++) if (ps == 2500 * (1 << k)) return 1'b1;
      return 1'b0;
   endfunction

   always @(clk_out) begin
      for (int i = 0; i < N; i++) begin
         if (prev_o[i] === 1'b0 && clk_out[i] === 1'b1) begin
            prev_rise_t[i] = rise_t[i];
            rise_t[i] = $realtime;
            rises[i] = rises[i] + 1;
         end else if (prev_o[i] === 1'b1 && clk_out[i] === 1'b0) begin
            hi_ps[i] = int'(($realtime - rise_t[i]) * 1000.0);
            if (!legal_width(hi_ps[i])) runts = runts + 1;
         end
      end
      prev_o = clk_out;
   end

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      reg_addr = 16'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(int a, output int d);
      @(negedge clk);
      reg_addr = 16'(a); reg_rd = 1'b1;
      #1;
      d = int'(reg_rdata);
      reg_rd = 1'b0;
   endtask

   task automatic enable_run(int ch, int code);
      int r, lim, k, first, r0;
      r = ratio(code);
      lim = 2 + 3 * r;
      wr(ch * 256 + 'h43, code);
      r0 = rises[ch];
      wr(ch * 256 + 'h46, 'h80);
      k = 0; first = -1;
      while (!running[ch] && k < 400) begin
         @(negedge clk);
         k++;
         if (first < 0 && rises[ch] != r0) first = k;
      end
      chk(k == lim, "R6 status rise latency", k, lim);
      chk(first > 0 && first <= lim, "R6 first output edge within bound", first, lim);
      repeat (2 * r + 2) @(negedge clk);
      chk(int'((rise_t[ch] - prev_rise_t[ch]) * 1000.0) == r * 5000, "R1 output period ps",
          int'((rise_t[ch] - prev_rise_t[ch]) * 1000.0), r * 5000);
      chk(hi_ps[ch] == r * 2500, "R1 high time ps", hi_ps[ch], r * 2500);
   endtask

   task automatic disable_run(int ch, int code);
      int r, k, rs;
      r = ratio(code);
      wr(ch * 256 + 'h46, 'h00);
      k = 0;
      while (running[ch] && k < 400) begin
         @(negedge clk);
         k++;
      end
      chk(k == 3 * r, "R7 status fall latency", k, 3 * r);
      rs = rises[ch];
      chk(clk_out[ch] == 1'b0, "R7 output low at status fall", int'(clk_out[ch]), 0);
      repeat (2 * r + 4) @(negedge clk);
      chk(rises[ch] == rs, "R7 output stays stopped", rises[ch] - rs, 0);
   endtask

   task automatic finish_run();
      chk(runts == 0, "R8 shortened high pulses", runts, 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      int d;
      void'($urandom(32'd20171013));
      for (int i = 0; i < N; i++) begin rises[i] = 0; hi_ps[i] = 0; rise_t[i] = 0; prev_rise_t[i] = 0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R5 reset state
      chk(running == '0, "R5 status low after reset", int'(running), 0);
      chk(clk_out == '0, "R5 outputs low after reset", int'(clk_out), 0);
      @(posedge clk); #1;
      chk(clk_out == '0, "R5 outputs low in high phase", int'(clk_out), 0);
      for (int c = 0; c < N; c++) begin
         rd(c * 256 + 'h43, d); chk(d == 0, "R5 divide code reset", d, 0);
         rd(c * 256 + 'h46, d); chk(d == 0, "R5 enable reset", d, 0);
      end

      // R2 field width, R3 enable bit position
      wr('h0043, 'hFF); rd('h0043, d); chk(d == 'h07, "R2 divide readback", d, 'h07);
      wr('h0043, 'h00);
      wr('h0046, 'h7F); rd('h0046, d); chk(d == 'h00, "R3 low bits ignored", d, 0);
      repeat (10) @(negedge clk);
      chk(running[0] == 1'b0, "R3 no enable from low bits", int'(running[0]), 0);

      // R10 read data idle
      wr('h0143, 'h05);
      @(negedge clk); reg_addr = 16'h0143; #1;
      chk(reg_rdata == 8'h00, "R10 rdata zero without strobe", int'(reg_rdata), 0);

      // R4 out-of-range index and unmapped offsets
      wr('h0343, 'h06); wr('h0346, 'h80); wr('h0144, 'h03);
      rd('h0343, d); chk(d == 0, "R4 index beyond bank reads zero", d, 0);
      rd('h0143, d); chk(d == 'h05, "R4 real register unchanged", d, 'h05);
      rd('h0144, d); chk(d == 0, "R4 unmapped offset reads zero", d, 0);
      chk(running == '0, "R4 no stray enable", int'(running), 0);

      // R1 code 0 and code 1 both unity
      enable_run(0, 0); disable_run(0, 0);
      enable_run(0, 1); disable_run(0, 1);

      // R3 readback of enable, R4 independence across outputs
      enable_run(0, 2);
      rd('h0046, d); chk(d == 'h80, "R3 enable readback", d, 'h80);
      enable_run(2, 4);
      repeat (6) @(negedge clk);
      chk(int'((rise_t[0] - prev_rise_t[0]) * 1000.0) == 10000, "R4 output 0 unaffected by output 2",
          int'((rise_t[0] - prev_rise_t[0]) * 1000.0), 10000);
      rd('h0146, d); chk(d == 0, "R4 output 1 enable untouched", d, 0);
      disable_run(0, 2); disable_run(2, 4);

      // R9 ratio change while running
      enable_run(1, 3);
      wr('h0143, 5);
      repeat (3 * 16 + 2) @(negedge clk);
      chk(int'((rise_t[1] - prev_rise_t[1]) * 1000.0) == 80000, "R9 new period after change",
          int'((rise_t[1] - prev_rise_t[1]) * 1000.0), 80000);
      chk(hi_ps[1] == 40000, "R9 new high time", hi_ps[1], 40000);
      disable_run(1, 5);

      // R6 R7 extreme ratio
      enable_run(2, 7); disable_run(2, 7);

      // random mix
      for (int it = 0; it < 10; it++) begin
         int ch, code, ofs;
         ch = int'($urandom % N);
         code = int'($urandom % 8);
         enable_run(ch, code);
         disable_run(ch, code);
         ofs = int'($urandom % 256);
         if (ofs != 'h43 && ofs != 'h46) begin
            rd(ch * 256 + ofs, d);
            chk(d == 0, "R4 random unmapped read", d, 0);
         end
      end

      finish_run();
   end
endmodule